// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment and Misalignment Trap Unit

This block sits between a processor's memory stage and a word-wide data memory. For a store it turns the access size and the byte offset inside the word into a per-byte write enable mask and moves the store data into the byte lanes that mask selects. For a load it takes the full word returned by memory, picks out the addressed byte or halfword and widens it to the data width with sign or zero extension, as the load variant asks.

Any access whose byte offset does not suit its size is reported on a trap output, and such a store writes nothing and such a load returns zero. A short chain of flip-flops that fills with ones after reset keeps the trap output low for the first cycles after reset release, so stale or undefined requests in that window cannot raise a false trap. All four outputs are registered: they reflect the request presented in the previous cycle. The upper address bits go straight to the memory and are not seen by this unit; only the byte offset inside the word arrives here.

Top module: `lsu_align`

## Requirements
- R1: Size encoding on `req_size`: 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 treated as word. One cycle after a valid aligned store, `wr_mask` is 4'b0001 shifted left by the offset for a byte (0001, 0010, 0100, 1000), 4'b0011 at offset 0 or 4'b1100 at offset 2 for a halfword, and 4'b1111 for a word.
- R2: One cycle after a valid store, `wr_data` equals `st_data` shifted left by 8 times the byte offset, so a byte or halfword lands in the lanes its mask enables.
- R3: One cycle after a valid aligned load, `ld_result` holds the byte (bits 8*off+7..8*off of `rd_data`) or halfword (bits 8*off+15..8*off) widened by copying its top bit when `req_unsigned` is 0 and with zeros when it is 1; a word load returns `rd_data` unchanged.
- R4: A halfword with offset bit 0 set, or a word with either offset bit set, is misaligned; once the reset chain is full, a valid misaligned request raises `trap_o` in the next cycle, and an aligned one leaves it low.
- R5: A misaligned store produces `wr_mask` of 0 and a misaligned load produces `ld_result` of 0.
- R6: A load never drives a nonzero `wr_mask`, and with `req_valid` low both `wr_mask` and `trap_o` are 0 in the next cycle whatever the other inputs are.
- R7: While `rst_n` is low all outputs are 0.
- R8: `trap_o` stays 0 at each of the first three rising clock edges after `rst_n` rises, whatever the request; from the fourth edge on, a misaligned valid request is trapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load or store is presented this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Access size code (see R1) |
| req_unsigned | input | 1 | Load widens with zeros instead of the sign bit |
| req_byte_off | input | 2 | Byte offset of the access inside the word |
| st_data | input | 32 | Store data, value in the low bits |
| rd_data | input | 32 | Word read from data memory for this load |
| wr_mask | output | 4 | Per-byte write enable for the store |
| wr_data | output | 32 | Store data moved into its byte lanes |
| ld_result | output | 32 | Extracted and widened load value |
| trap_o | output | 1 | Misaligned access trap |

## Verification
The assertions assume that `rd_data` arrives in the same cycle as its load request and that the request inputs hold defined values from the first clock edge after reset, since several properties look one cycle back at them. The stimulus keeps to this by driving every input to a known value before reset release and changing inputs only on the falling clock edge, with a misaligned request held across reset release so the start-up suppression window is exercised while the trap condition is present.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    // Number of bytes an access of the given size touches.
    function automatic int unsigned size_bytes(acc_size_e sz, int unsigned word_bytes);
        case (sz)
            SZ_BYTE: size_bytes = 1;
            SZ_HALF: size_bytes = 2;
            default: size_bytes = word_bytes;
        endcase
    endfunction

endpackage

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [BYTES-1:0]   mask_o,
    output logic [DATA_W-1:0]  data_o
);

    int unsigned nbytes;
    int unsigned first;

    always_comb begin
        nbytes = size_bytes(size_i, BYTES);
        first  = int'(off_i);
    end

    // One enable per lane: lane is covered when it falls in [off, off+n).
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        always_comb begin
            mask_o[g] = (g >= first) && (g < first + nbytes);
        end
    end

    always_comb begin
        data_o = data_i << {off_i, 3'b000};
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  acc_size_e          size_i,
    input  logic               zext_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [DATA_W-1:0]  word_i,
    output logic [DATA_W-1:0]  value_o
);

    logic [DATA_W-1:0] shifted;
    logic              fill8;
    logic              fill16;

    always_comb begin
        shifted = word_i >> {off_i, 3'b000};
        fill8   = shifted[7]  & ~zext_i;
        fill16  = shifted[15] & ~zext_i;
        case (size_i)
            SZ_BYTE: value_o = {{(DATA_W-8){fill8}},  shifted[7:0]};
            SZ_HALF: value_o = {{(DATA_W-16){fill16}}, shifted[15:0]};
            default: value_o = word_i;
        endcase
    end

endmodule

// File: rtl/lsu_rst_chain.sv
module lsu_rst_chain #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);

    logic [DEPTH-1:0] chain_d;
    logic [DEPTH-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], 1'b1};
        ready_o = chain_q[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
    import lsu_align_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int HOLD_DEPTH = 3,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [OFF_W-1:0]  req_byte_off,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic [BYTES-1:0]  wr_mask,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ld_result,
    output logic              trap_o
);

    typedef struct packed {
        logic [BYTES-1:0]  mask;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] ldata;
        logic              trap;
    } out_t;

    acc_size_e         size_e;
    logic [BYTES-1:0]  lane_mask;
    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] load_val;
    logic              trap_en;
    logic              misaligned;
    out_t              out_d;
    out_t              out_q;

    always_comb begin
        size_e = acc_size_e'(req_size);
    end

    lsu_store_lane #(.DATA_W(DATA_W)) u_store_lane (
        .size_i (size_e),
        .off_i  (req_byte_off),
        .data_i (st_data),
        .mask_o (lane_mask),
        .data_o (lane_data)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_load_extract (
        .size_i  (size_e),
        .zext_i  (req_unsigned),
        .off_i   (req_byte_off),
        .word_i  (rd_data),
        .value_o (load_val)
    );

    lsu_rst_chain #(.DEPTH(HOLD_DEPTH)) u_rst_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_o (trap_en)
    );

    always_comb begin
        // Offset bits below the access size must be zero.
        misaligned = |(req_byte_off & OFF_W'(size_bytes(size_e, BYTES) - 1));

        out_d = '0;
        if (req_valid) begin
            if (req_store) begin
                out_d.wdata = lane_data;
                out_d.mask  = misaligned ? '0 : lane_mask;
            end else begin
                out_d.ldata = misaligned ? '0 : load_val;
            end
            out_d.trap = misaligned & trap_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        wr_mask   = out_q.mask;
        wr_data   = out_q.wdata;
        ld_result = out_q.ldata;
        trap_o    = out_q.trap;
    end

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
    parameter int DATA_W     = 32,
    parameter int HOLD_DEPTH = 3,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic              req_unsigned,
    input logic [OFF_W-1:0]  req_byte_off,
    input logic [BYTES-1:0]  wr_mask,
    input logic [DATA_W-1:0] ld_result,
    input logic              trap_o
);

    // Edges since reset release, saturating just past the hold window.
    logic [7:0] edges;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges <= '0;
        end else if (int'(edges) <= HOLD_DEPTH) begin
            edges <= edges + 8'd1;
        end
    end

    assert_trap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(edges) <= HOLD_DEPTH) |-> !trap_o);

    assert_word_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(edges) >= HOLD_DEPTH) && req_valid && req_size[1] && (req_byte_off != '0))
        |=> trap_o);

    assert_trap_nomask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (wr_mask == '0));

    assert_mask_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wr_mask) <= 2) || ($countones(wr_mask) == BYTES));

    assert_load_nomask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_store) |=> (wr_mask == '0));

    assert_byte_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && (req_size == 2'b00) && !req_unsigned)
        |=> (ld_result[DATA_W-1:8] == {(DATA_W-8){ld_result[7]}}));

endmodule

bind lsu_align lsu_align_chk #(.DATA_W(DATA_W), .HOLD_DEPTH(HOLD_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_size     (req_size),
    .req_unsigned (req_unsigned),
    .req_byte_off (req_byte_off),
    .wr_mask      (wr_mask),
    .ld_result    (ld_result),
    .trap_o       (trap_o)
);

// File: tb/lsu_align_tb.sv
module lsu_align_tb;

    localparam logic [31:0] SD = 32'h5566_77F8;
    localparam logic [31:0] RD = 32'h80F1_7E92;
    localparam int NVEC = 21;

    // {store, size[1:0], unsigned, off[1:0], mask[3:0], trap, check_val, val[31:0]}
    localparam logic [43:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 1'b0, 2'd0, 4'b0001, 1'b0, 1'b1, 32'h5566_77F8},
        {1'b1, 2'd0, 1'b0, 2'd1, 4'b0010, 1'b0, 1'b1, 32'h6677_F800},
        {1'b1, 2'd0, 1'b0, 2'd2, 4'b0100, 1'b0, 1'b1, 32'h77F8_0000},
        {1'b1, 2'd0, 1'b0, 2'd3, 4'b1000, 1'b0, 1'b1, 32'hF800_0000},
        {1'b1, 2'd1, 1'b0, 2'd0, 4'b0011, 1'b0, 1'b1, 32'h5566_77F8},
        {1'b1, 2'd1, 1'b0, 2'd2, 4'b1100, 1'b0, 1'b1, 32'h77F8_0000},
        {1'b1, 2'd2, 1'b0, 2'd0, 4'b1111, 1'b0, 1'b1, 32'h5566_77F8},
        {1'b1, 2'd1, 1'b0, 2'd1, 4'b0000, 1'b1, 1'b0, 32'h0000_0000},
        {1'b1, 2'd2, 1'b0, 2'd2, 4'b0000, 1'b1, 1'b0, 32'h0000_0000},
        {1'b0, 2'd0, 1'b0, 2'd0, 4'b0000, 1'b0, 1'b1, 32'hFFFF_FF92},
        {1'b0, 2'd0, 1'b1, 2'd0, 4'b0000, 1'b0, 1'b1, 32'h0000_0092},
        {1'b0, 2'd0, 1'b0, 2'd1, 4'b0000, 1'b0, 1'b1, 32'h0000_007E},
        {1'b0, 2'd0, 1'b0, 2'd2, 4'b0000, 1'b0, 1'b1, 32'hFFFF_FFF1},
        {1'b0, 2'd0, 1'b1, 2'd3, 4'b0000, 1'b0, 1'b1, 32'h0000_0080},
        {1'b0, 2'd0, 1'b0, 2'd3, 4'b0000, 1'b0, 1'b1, 32'hFFFF_FF80},
        {1'b0, 2'd1, 1'b0, 2'd0, 4'b0000, 1'b0, 1'b1, 32'h0000_7E92},
        {1'b0, 2'd1, 1'b0, 2'd2, 4'b0000, 1'b0, 1'b1, 32'hFFFF_80F1},
        {1'b0, 2'd1, 1'b1, 2'd2, 4'b0000, 1'b0, 1'b1, 32'h0000_80F1},
        {1'b0, 2'd2, 1'b0, 2'd0, 4'b0000, 1'b0, 1'b1, 32'h80F1_7E92},
        {1'b0, 2'd2, 1'b0, 2'd1, 4'b0000, 1'b1, 1'b1, 32'h0000_0000},
        {1'b0, 2'd1, 1'b0, 2'd3, 4'b0000, 1'b1, 1'b1, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [1:0]  req_byte_off = 2'b00;
    logic [31:0] st_data = SD;
    logic [31:0] rd_data = RD;
    logic [3:0]  wr_mask;
    logic [31:0] wr_data;
    logic [31:0] ld_result;
    logic        trap_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    lsu_align u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_store    (req_store),
        .req_size     (req_size),
        .req_unsigned (req_unsigned),
        .req_byte_off (req_byte_off),
        .st_data      (st_data),
        .rd_data      (rd_data),
        .wr_mask      (wr_mask),
        .wr_data      (wr_data),
        .ld_result    (ld_result),
        .trap_o       (trap_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic st, input logic [1:0] sz,
                         input logic uns, input logic [1:0] off);
        @(negedge clk);
        req_valid    = v;
        req_store    = st;
        req_size     = sz;
        req_unsigned = uns;
        req_byte_off = off;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R7: outputs zero in reset, even with a misaligned store presented.
        drive(1'b1, 1'b1, 2'd2, 1'b0, 2'd2);
        settle();
        settle();
        check("R7 mask in reset", {28'd0, wr_mask}, 32'd0);
        check("R7 wdata in reset", wr_data, 32'd0);
        check("R7 load in reset", ld_result, 32'd0);
        check("R7 trap in reset", {31'd0, trap_o}, 32'd0);

        // R8: release reset with the misaligned store held.
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            settle();
            check((k <= 3) ? "R8 trap held low" : "R8 trap after window",
                  {31'd0, trap_o}, (k <= 3) ? 32'd0 : 32'd1);
            check("R5 misaligned store mask", {28'd0, wr_mask}, 32'd0);
        end

        // Table walk: R1 R2 R3 R4 R5.
        for (int i = 0; i < NVEC; i++) begin
            logic [43:0] v;
            v = VEC[i];
            drive(1'b1, v[43], v[42:41], v[40], v[39:38]);
            settle();
            check(v[43] ? "R1 store mask" : "R6 load mask", {28'd0, wr_mask}, {28'd0, v[37:34]});
            check("R4 trap", {31'd0, trap_o}, {31'd0, v[33]});
            if (v[32]) begin
                if (v[43]) check("R2 store data", wr_data, v[31:0]);
                else       check(v[33] ? "R5 misaligned load" : "R3 load value", ld_result, v[31:0]);
            end
        end

        // R6: idle request with misaligned store fields.
        drive(1'b0, 1'b1, 2'd2, 1'b0, 2'd1);
        settle();
        check("R6 idle mask", {28'd0, wr_mask}, 32'd0);
        check("R6 idle trap", {31'd0, trap_o}, 32'd0);

        // R1: size code 2'b11 behaves as word.
        drive(1'b1, 1'b1, 2'd3, 1'b0, 2'd0);
        settle();
        check("R1 alt word mask", {28'd0, wr_mask}, 32'h0000_000F);
        drive(1'b1, 1'b1, 2'd3, 1'b0, 2'd3);
        settle();
        check("R4 alt word trap", {31'd0, trap_o}, 32'd1);

        // R7/R8: reset mid-run, then the window again.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R7 async reset trap", {31'd0, trap_o}, 32'd0);
        check("R7 async reset mask", {28'd0, wr_mask}, 32'd0);
        drive(1'b1, 1'b0, 2'd1, 1'b0, 2'd1);
        rst_n = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            settle();
            check((k <= 3) ? "R8 trap held low again" : "R8 trap enabled again",
                  {31'd0, trap_o}, (k <= 3) ? 32'd0 : 32'd1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule